// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single down-counting timer channel. It divides a fixed-rate input tick into a periodic output waveform, and it pulses an interrupt request once per output period. Software first writes a control byte to the command port. The control byte names the channel and selects the waveform shape. Software then writes two bytes to the data port, low byte first and high byte second, to load a 16-bit divisor. A divisor of N gives one output period every N input ticks. With a 1.193182 MHz tick, a divisor of 11931 gives a period close to 10 ms.

Two waveform shapes are available. The first is a near-50% square wave. The second is a rate generator whose output drops low for one tick in each period. A control byte that names a different channel, or that asks for an unsupported access pattern, counting code or mode, is dropped without any effect. Loading a new divisor while the channel is counting does not disturb the period already in progress.

Top module: `interval_timer_channel`

## Requirements
- R1: Reset leaves the channel idle. `wave_out` is 1, `irq` is 0, no divisor is pending, and the next data byte is taken as a low byte.
- R2: A command-port byte is accepted only when all of these hold: bits 7:6 equal the channel number (0 by default), bits 5:4 are 2'b11, bit 0 is 0 (binary counting), and bit 2 is 1 (mode field bits 3:1 equal 2, 3, 6 or 7). Any other command byte leaves the waveform, the pending divisor and the byte order unchanged.
- R3: An accepted command byte stops the count, discards any pending divisor and resets the byte order to the low byte. From the next cycle `wave_out` is 1 and stays 1 until a new divisor is loaded.
- R4: Data-port bytes alternate low byte, high byte. A divisor becomes pending only when its high byte is written. A lone low byte has no effect on the output.
- R5: When the channel is idle and a divisor is pending, the first input tick starts counting with the output high. With ticks on every cycle, the first `irq` appears N+1 cycles after the high-byte write ends.
- R6: Square mode (mode field bit 1 = 1 after accept, i.e. bits 3:1 = 3 or 7): the output is high for ceil(N/2) ticks and low for floor(N/2) ticks in each period.
- R7: Rate mode (bits 3:1 = 2 or 6): the output is high for N-1 ticks and low for 1 tick in each period.
- R8: A written divisor of 0 counts as 65536.
- R9: `irq` is a one-cycle pulse in the cycle after the tick that ends each period. The tick that starts counting does not raise it.
- R10: A divisor written while counting takes effect at the next period boundary. The current period finishes with the old divisor.
- R11: The count advances only on cycles with `tick_en` high. Without ticks, `wave_out` holds and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable for each input tick of the counter |
| wr_en | input | 1 | Write strobe for one byte |
| wr_ctrl | input | 1 | 1 selects the command port, 0 selects the data port |
| wr_data | input | 8 | Byte being written |
| wave_out | output | 1 | Divided output waveform |
| irq | output | 1 | One-cycle pulse at each period boundary |

## Verification
The bench aims at odd divisors, where a design that splits the period evenly would show a 3/3 wave for N=7 instead of 4/3. It also covers the divisor of zero, where a design without the 65536 mapping would stop or wrap at once. Reprogramming in mid-period is tested too: a design that reloads at once would shorten the running period. Malformed command bytes are placed between the two data bytes. A design that accepted them, or that reset the byte order on them, would assemble the wrong divisor. An accepted command byte is also tested between a completed divisor and the first tick. A design that kept the pending divisor across that command would start counting when it should stay high.

// File: rtl/ictc_pkg.sv
// Shared types for the interval timer channel.
// Assumes an 8-bit command byte; field positions are fixed by the command format.
package ictc_pkg;

    localparam int CTRL_W = 8;

    // Command byte fields, most significant first.
    typedef struct packed {
        logic [1:0] chan;
        logic [1:0] access;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    typedef enum logic {
        WAVE_RATE   = 1'b0,
        WAVE_SQUARE = 1'b1
    } wave_t;

    localparam logic [1:0] ACCESS_LO_HI = 2'b11;

endpackage

// File: rtl/ictc_ctrl_decode.sv
// Command byte filter.
// Decides whether a command-port write is accepted and which waveform it selects.
// Assumes the command byte sits in the low 8 bits of the write data.
module ictc_ctrl_decode
    import ictc_pkg::*;
#(
    parameter logic [1:0] CHANNEL_ID = 2'd0
) (
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] cmd_byte,
    output logic              ctrl_accept,
    output wave_t             wave_sel
);

    ctrl_word_t cw;

    // Field split and acceptance test.
    always_comb begin
        cw          = ctrl_word_t'(cmd_byte);
        ctrl_accept = wr_en && wr_ctrl
                      && (cw.chan == CHANNEL_ID)
                      && (cw.access == ACCESS_LO_HI)
                      && !cw.bcd
                      && cw.mode[1];
        wave_sel    = cw.mode[0] ? WAVE_SQUARE : WAVE_RATE;
    end

endmodule

// File: rtl/ictc_load_path.sv
// Divisor assembly.
// Collects a low byte and then a high byte into a pending divisor. An accepted
// command clears both the pending divisor and the byte order. A raw value of
// zero becomes 2**CNT_W. Assumes the core signals 'consume' only while pending is valid.
module ictc_load_path #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W,
    localparam int DIV_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_accept,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              consume,
    output logic              pend_valid,
    output logic [DIV_W-1:0]  pend_div
);

    logic              byte_hi;
    logic [BYTE_W-1:0] lo_q;
    logic [CNT_W-1:0]  raw_div;
    logic [DIV_W-1:0]  full_div;

    // Join the incoming high byte with the stored low byte; map zero to the maximum.
    always_comb begin
        raw_div  = {data_byte, lo_q};
        full_div = (raw_div == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, raw_div};
    end

    // Byte order, low-byte holding register and the pending divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_hi    <= 1'b0;
            lo_q       <= '0;
            pend_valid <= 1'b0;
            pend_div   <= DIV_W'(1);
        end else if (ctrl_accept) begin
            byte_hi    <= 1'b0;
            pend_valid <= 1'b0;
        end else begin
            if (consume)
                pend_valid <= 1'b0;
            if (data_wr) begin
                if (!byte_hi) begin
                    lo_q    <= data_byte;
                    byte_hi <= 1'b1;
                end else begin
                    byte_hi    <= 1'b0;
                    pend_div   <= full_div;
                    pend_valid <= 1'b1;
                end
            end
        end
    end

    AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_accept |=> !byte_hi); // R3

    AST_PEND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_div != '0)); // R8

endmodule

// File: rtl/ictc_count_core.sv
// Period counter and waveform shaper.
// Counts input ticks within the current period and derives the output level
// from the position and the selected shape. Marks each period boundary with irq.
// Assumes pend_div is never zero while pend_valid is set.
module ictc_count_core
    import ictc_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int DIV_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ctrl_accept,
    input  wave_t            wave_sel,
    input  logic             pend_valid,
    input  logic [DIV_W-1:0] pend_div,
    output logic             consume,
    output logic             wave_out,
    output logic             irq
);

    logic             armed;
    logic [DIV_W-1:0] pos;
    logic [DIV_W-1:0] cur_div;
    logic [DIV_W-1:0] high_len;
    logic             last_tick;
    wave_t            wave_q;

    // End-of-period detection and the length of the high phase.
    always_comb begin
        last_tick = (pos == cur_div - DIV_W'(1));
        high_len  = (wave_q == WAVE_SQUARE) ? (cur_div - (cur_div >> 1))
                                            : (cur_div - DIV_W'(1));
        consume   = !ctrl_accept && tick_en && pend_valid && (!armed || last_tick);
        wave_out  = !armed || (pos < high_len);
    end

    // Counting state: start, advance, wrap with reload at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            pos     <= '0;
            cur_div <= DIV_W'(1);
            wave_q  <= WAVE_SQUARE;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (ctrl_accept) begin
                armed  <= 1'b0;
                wave_q <= wave_sel;
            end else if (tick_en) begin
                if (!armed) begin
                    if (pend_valid) begin
                        armed   <= 1'b1;
                        cur_div <= pend_div;
                        pos     <= '0;
                    end
                end else if (last_tick) begin
                    pos <= '0;
                    irq <= 1'b1;
                    if (pend_valid)
                        cur_div <= pend_div;
                end else begin
                    pos <= pos + DIV_W'(1);
                end
            end
        end
    end

    AST_POS_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (pos < cur_div)); // R5

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cur_div != '0)); // R8

    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick_en)); // R9

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(pos)); // R11

endmodule

// File: rtl/interval_timer_channel.sv
// One interval timer channel: command filter, divisor assembly and period counter.
// Command and data share one write strobe; wr_ctrl picks the port.
// Assumes tick_en is a one-cycle pulse per input tick, synchronous to clk.
module interval_timer_channel
    import ictc_pkg::*;
#(
    parameter int         BYTE_W     = 8,
    parameter logic [1:0] CHANNEL_ID = 2'd0,
    localparam int        CNT_W      = 2 * BYTE_W,
    localparam int        DIV_W      = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wave_out,
    output logic              irq
);

    logic             ctrl_accept;
    wave_t            wave_sel;
    logic             data_wr;
    logic             consume;
    logic             pend_valid;
    logic [DIV_W-1:0] pend_div;

    // Data-port strobe.
    assign data_wr = wr_en && !wr_ctrl;

    ictc_ctrl_decode #(.CHANNEL_ID(CHANNEL_ID)) u_decode (
        .wr_en       (wr_en),
        .wr_ctrl     (wr_ctrl),
        .cmd_byte    (wr_data[CTRL_W-1:0]),
        .ctrl_accept (ctrl_accept),
        .wave_sel    (wave_sel)
    );

    ictc_load_path #(.BYTE_W(BYTE_W)) u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_accept (ctrl_accept),
        .data_wr     (data_wr),
        .data_byte   (wr_data),
        .consume     (consume),
        .pend_valid  (pend_valid),
        .pend_div    (pend_div)
    );

    ictc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .ctrl_accept (ctrl_accept),
        .wave_sel    (wave_sel),
        .pend_valid  (pend_valid),
        .pend_div    (pend_div),
        .consume     (consume),
        .wave_out    (wave_out),
        .irq         (irq)
    );

    AST_CTRL_IDLES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_accept |=> wave_out); // R3

    AST_REJECTED_CMD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ctrl && !ctrl_accept && !tick_en) |=> $stable(wave_out)); // R2

endmodule

// File: tb/interval_timer_channel_test.sv
// Self-checking bench. A behavioural reference model is updated on every
// rising edge and compared with the outputs on every falling edge. Directed
// checks measure the phase lengths and the periods.
module interval_timer_channel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wave_out;
    logic       irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    int    tick_mode = 0;
    string phase = "R1";
    logic [15:0] lfsr = 16'hACE1;

    interval_timer_channel uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_ctrl(wr_ctrl), .wr_data(wr_data), .wave_out(wave_out), .irq(irq)
    );

    always #10 clk = ~clk;

    // Reference model state.
    int m_armed, m_pos, m_cur, m_pend, m_pvalid, m_hi, m_lo, m_sq, m_irq;

    function automatic int cmd_ok(input logic [7:0] b);
        return (b[7:6] == 2'b00) && (b[5:4] == 2'b11) && !b[0] && b[2];
    endfunction

    function automatic int m_out();
        int h;
        h = m_sq ? (m_cur - m_cur / 2) : (m_cur - 1);
        return (!m_armed || (m_pos < h)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int old_pv, old_pd, acc, nd;
        if (!rst_n) begin
            m_armed = 0; m_pos = 0; m_cur = 1; m_pend = 1; m_pvalid = 0;
            m_hi = 0; m_lo = 0; m_sq = 1; m_irq = 0;
        end else begin
            m_irq  = 0;
            old_pv = m_pvalid;
            old_pd = m_pend;
            acc    = wr_en && wr_ctrl && cmd_ok(wr_data);
            if (acc) begin
                m_armed = 0; m_hi = 0; m_pvalid = 0; m_sq = wr_data[1];
            end else begin
                if (tick_en) begin
                    if (!m_armed) begin
                        if (old_pv) begin
                            m_armed = 1; m_cur = old_pd; m_pos = 0; m_pvalid = 0;
                        end
                    end else if (m_pos == m_cur - 1) begin
                        m_pos = 0; m_irq = 1;
                        if (old_pv) begin m_cur = old_pd; m_pvalid = 0; end
                    end else begin
                        m_pos = m_pos + 1;
                    end
                end
                if (wr_en && !wr_ctrl) begin
                    if (!m_hi) begin
                        m_lo = wr_data; m_hi = 1;
                    end else begin
                        nd = wr_data * 256 + m_lo;
                        if (nd == 0) nd = 65536;
                        m_pend = nd; m_pvalid = 1; m_hi = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Every-cycle comparison against the model, and the watchdog.
    always @(negedge clk) begin
        cycles++;
        chk({phase, " out"}, int'(wave_out), m_out());
        chk({phase, " irq"}, int'(irq), m_irq);
        if (cycles > 190000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Tick generator: 0 every cycle, 1 pseudo-random, 2 none.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (tick_mode)
            0: tick_en = 1'b1;
            1: tick_en = lfsr[0] & ~lfsr[5];
            default: tick_en = 1'b0;
        endcase
    end

    task automatic write_byte(input logic ctl, input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_ctrl = ctl; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0; wr_ctrl = 1'b0;
    endtask

    task automatic measure(output int hi, output int lo);
        int g;
        g = 0; hi = 0; lo = 0;
        @(negedge clk);
        while (!irq && g < 70000) begin @(negedge clk); g++; end
        do begin
            if (wave_out) hi++; else lo++;
            @(negedge clk); g++;
        end while (!irq && g < 140000);
    endtask

    task automatic quiet(input int n, input int exp_out, input string req);
        int hi_cnt, irq_cnt;
        hi_cnt = 0; irq_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wave_out == exp_out) hi_cnt++;
            if (irq) irq_cnt++;
        end
        chk({req, " level held"}, hi_cnt, n);
        chk({req, " no irq"}, irq_cnt, 0);
    endtask

    initial begin
        int hi, lo, c, h;
        repeat (3) @(negedge clk);
        chk("R1 reset out", int'(wave_out), 1);
        chk("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 start latency, square N=4
        phase = "R5";
        write_byte(1, 8'h36); write_byte(0, 8'd4); write_byte(0, 8'd0);
        c = 0;
        while (!irq && c < 100) begin @(negedge clk); c++; end
        chk("R5 first irq latency", c, 5);

        phase = "R6";
        measure(hi, lo); chk("R6 even high", hi, 2); chk("R6 even low", lo, 2);
        write_byte(1, 8'h36); write_byte(0, 8'd7); write_byte(0, 8'd0);
        measure(hi, lo); chk("R6 odd high", hi, 4); chk("R6 odd low", lo, 3);

        phase = "R7";
        write_byte(1, 8'h34); write_byte(0, 8'd5); write_byte(0, 8'd0);
        measure(hi, lo); chk("R7 rate high", hi, 4); chk("R7 rate low", lo, 1);

        // R2 rejected command bytes while counting
        phase = "R2";
        write_byte(1, 8'h76); write_byte(1, 8'h37); write_byte(1, 8'h16);
        write_byte(1, 8'h30); write_byte(1, 8'h32);
        measure(hi, lo); chk("R2 wave kept high", hi, 4); chk("R2 wave kept low", lo, 1);
        write_byte(0, 8'd3); write_byte(1, 8'h37); write_byte(0, 8'd0);
        measure(hi, lo); chk("R2 byte order kept high", hi, 2); chk("R2 byte order kept low", lo, 1);

        // R10 reprogram mid-period
        phase = "R10";
        write_byte(0, 8'd8); write_byte(0, 8'd0);
        measure(hi, lo); chk("R10 new high", hi, 7); chk("R10 new low", lo, 1);

        // R3 command stops counting
        phase = "R3";
        write_byte(1, 8'h36);
        chk("R3 out high after command", int'(wave_out), 1);
        quiet(12, 1, "R3 idle");

        // R4 lone low byte
        phase = "R4";
        write_byte(0, 8'd9);
        quiet(12, 1, "R4 low byte only");
        write_byte(0, 8'd0);
        measure(hi, lo); chk("R4 high", hi, 5); chk("R4 low", lo, 4);

        // R3 pending divisor discarded by a command
        phase = "R3";
        tick_mode = 2;
        write_byte(1, 8'h36); write_byte(0, 8'd5); write_byte(0, 8'd0);
        write_byte(1, 8'h34);
        tick_mode = 0;
        quiet(12, 1, "R3 pending dropped");

        // R11 no ticks, then random ticks
        phase = "R11";
        write_byte(0, 8'd6); write_byte(0, 8'd0);
        repeat (3) @(negedge clk);
        tick_mode = 2;
        repeat (2) @(negedge clk);
        h = int'(wave_out);
        quiet(20, h, "R11 frozen");
        tick_mode = 1;
        repeat (300) @(negedge clk);
        tick_mode = 0;
        repeat (2) @(negedge clk);

        // R8 divisor zero means 65536
        phase = "R8";
        write_byte(1, 8'h36); write_byte(0, 8'd0); write_byte(0, 8'd0);
        c = 0; hi = 0;
        while (!irq && c < 70000) begin
            @(negedge clk); c++;
            if (!irq && wave_out) hi++;
        end
        chk("R8 full period", c, 65537);
        chk("R8 half high", hi, 32768);
        phase = "R9";
        @(negedge clk);
        chk("R9 irq single cycle", int'(irq), 0);
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule